// File: doc/BRIEF.md
# Sector Controller Host Register Port

This block is the register window through which a host processor drives a disc sector controller. A 4-bit index picks one register. Reads and writes use two different sixteen-entry maps. After each access the index steps to the next entry, so the host can set the index once and then stream through a group of registers. Some accesses have side effects. Writes start or abort transfers, acknowledge the end of a transfer and set the decoding mode. Reading the last status register acknowledges the decoder event.

The transfer and decoder datapaths connect through plain strobes and flags. `dec_event` reports a decoded block and its header. `hdr_alt_wr` loads the second header set. `xfer_end` reports that a transfer has finished. `xfer_start` tells the transfer engine to begin, and `byte_count` and `data_addr` give it its parameters. The end-of-transfer and decoder-event flags are active low. Each has an enable bit in the interface control register. Together with the external `lvl5_en` gate they form the combined level-5 request `irq5`.

Interface status byte (read index 1):
- bit 6: transfer-end pending, active low
- bit 5: decoder-event pending, active low
- bit 3: busy, active low
- bit 1: data-ready, active low
- all other bits read 1

Interface control register (write index 1):
- bit 6: transfer-end interrupt enable
- bit 5: decoder interrupt enable
- bit 1: output enable

Top module: `sctl_regport`

## Requirements
- R1: After reset:
  - `index` is 0, `irq5`, `xfer_start` and `eod` are 0, and both 16-bit pairs are 0.
  - The status byte reads 0xFF.
  - Header set 0 reads bytes 00,00,00,01 at indices 4..7, and header set 1 reads all zeros.
  - STAT0 and STAT2 read 0x00 and STAT3 reads 0x80.
- R2: A write at any nonzero index advances `index` by one, and a write at index 15 leaves `index` at 0. A read or write at index 0 leaves all state and `index` unchanged, and a read there returns 0. `idx_load` has priority over both accesses, and a write has priority over a read in the same cycle.
- R3: The read map:
  - 1 gives the status byte.
  - 2/3 give the count low/high.
  - 4..7 give header bytes 0..3.
  - 8/9 give `blk_ptr` low/high.
  - 10/11 give `wr_addr` low/high.
  - 12..15 give STAT0..STAT3. STAT1 (13) always reads 0.

  Each read at a nonzero index advances `index`, and a read at 15 wraps it to 0.
- R4: Byte count and data address each have a low and a high write index (2/3 and 4/5). A low write replaces bits 7:0. A high write ORs the data into bits 15:8.
- R5: Bit 0 of CTRL1 (write index 11) selects the header set that indices 4..7 return. Header byte k is `hdr_in[8k+7:8k]`.
- R6: A write to index 1 stores the interface control register. If bit 1 of the written data is 0, the busy and data-ready flags go to 1.
- R7: A write to index 6 while output enable is set does four things:
  - It pulses `xfer_start` for one cycle.
  - It drives busy low, and drives data-ready low when `dest_host` is 1.
  - It clears count bits 15:12.
  - It clears `eod`.

  With output enable clear, the write changes nothing but `index`.
- R8: A write to index 7 sets the transfer-end flag to 1 and clears count bits 15:12.
- R9: A write to CTRL0 (index 10) sets STAT0 to data & 0x80 and sets `dec_enable` to bit 7 of CTRL0. After a write to CTRL0 or CTRL1 (index 11), STAT2 depends on CTRL0 bit 4:
  - If bit 4 is set, STAT2 is CTRL1 & 0x08.
  - If bit 4 is clear, STAT2 is CTRL1 & 0x0C.
- R10: Reading index 15 returns STAT3, then loads STAT3 with 0x80 and sets the decoder-event flag to 1.
- R11: `irq5` is 1 exactly when `lvl5_en` is 1 and at least one of these holds:
  - Control bit 6 is set and the transfer-end flag is 0.
  - Control bit 5 is set and the decoder-event flag is 0.
- R12: A write to index 15 returns every register to its R1 value and sets `index` to 0.
- R13: A `dec_event` while CTRL0 bit 7 is set does three things:
  - It loads header set 0 from `hdr_in`.
  - It sets STAT3 to 0x00.
  - It drives the decoder-event flag low.

  While CTRL0 bit 7 is clear, a `dec_event` has no effect.
- R14: An `xfer_end` pulse sets busy and data-ready to 1, drives the transfer-end flag low and sets `eod`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_load | input | 1 | Load `idx_in` into the index |
| idx_in | input | 4 | New index value |
| wr_en | input | 1 | Host write strobe at the current index |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe; applies the read side effects and advances the index |
| rd_data | output | 8 | Register at the current index (combinational) |
| index | output | 4 | Current register index |
| dec_event | input | 1 | Decoder finished a block |
| hdr_alt_wr | input | 1 | Load header set 1 from `hdr_in` |
| hdr_in | input | 32 | Header bytes, byte k at bits 8k+7:8k |
| blk_ptr | input | 16 | Block pointer from the decoder |
| wr_addr | input | 16 | Buffer write address from the decoder |
| dest_host | input | 1 | Transfer goes to host reads |
| xfer_end | input | 1 | Transfer engine finished |
| lvl5_en | input | 1 | External level-5 interrupt gate |
| irq5 | output | 1 | Combined level-5 request |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| byte_count | output | 16 | Transfer byte count |
| data_addr | output | 16 | Transfer buffer address |
| eod | output | 1 | End of data, set by `xfer_end`, cleared by a start |
| dec_enable | output | 1 | CTRL0 bit 7, decoding enabled |

## Verification
The bench targets three groups of corner cases.

Index movement:
- Wrap to 0 after STAT3 is read and after the reset write.
- Accesses at index 0 that must leave the index alone.

A design that advanced the wrong way would read the wrong register on every following access.

High-byte writes:
- The OR merge of a high-byte write. A design that replaced the byte would lose bits already present.
- The upper-nibble clear on start and on acknowledge, each checked against a count that had those bits set.

Conditional side effects:
- A start while output is disabled, and a decode event while decoding is off. Each must leave the status byte and the header unchanged.
- The interplay of the active-low flags with the enable bits and `lvl5_en` in `irq5`. A polarity slip there shows up as a request raised or dropped at the wrong moment.

// File: rtl/sctl_regport_pkg.sv
package sctl_regport_pkg;

   // register indices whose position the host software relies on
   localparam logic [3:0] IX_NONE   = 4'h0;
   localparam logic [3:0] IX_IFACE  = 4'h1;
   localparam logic [3:0] IX_CNT_LO = 4'h2;
   localparam logic [3:0] IX_CNT_HI = 4'h3;
   localparam logic [3:0] IX_ADR_LO = 4'h4;
   localparam logic [3:0] IX_ADR_HI = 4'h5;
   localparam logic [3:0] IX_TRIG   = 4'h6;
   localparam logic [3:0] IX_ACK    = 4'h7;
   localparam logic [3:0] IX_CTL0   = 4'hA;
   localparam logic [3:0] IX_CTL1   = 4'hB;
   localparam logic [3:0] IX_SRST   = 4'hF;

   // read side
   localparam logic [3:0] IX_HDR0   = 4'h4;
   localparam logic [3:0] IX_HDR3   = 4'h7;
   localparam logic [3:0] IX_PTR_LO = 4'h8;
   localparam logic [3:0] IX_PTR_HI = 4'h9;
   localparam logic [3:0] IX_WA_LO  = 4'hA;
   localparam logic [3:0] IX_WA_HI  = 4'hB;
   localparam logic [3:0] IX_ST0    = 4'hC;
   localparam logic [3:0] IX_ST1    = 4'hD;
   localparam logic [3:0] IX_ST2    = 4'hE;
   localparam logic [3:0] IX_ST3    = 4'hF;

   // bit positions
   localparam int B_XE_EN   = 6;
   localparam int B_DEC_EN  = 5;
   localparam int B_OUT_EN  = 1;
   localparam int B_DECODE  = 7;
   localparam int B_AUTO    = 4;
   localparam int B_BANKSEL = 0;

   localparam logic [7:0] M_MODE_ONLY = 8'h08;
   localparam logic [7:0] M_MODE_FORM = 8'h0C;
   localparam logic [7:0] ST3_IDLE    = 8'h80;

   typedef struct packed {
      logic xe_n;
      logic dec_n;
      logic busy_n;
      logic data_n;
   } if_flags_t;

endpackage

// File: rtl/sctl_index_step.sv
module sctl_index_step #(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          load,
   input  logic [IW-1:0] load_val,
   input  logic          step,
   output logic [IW-1:0] idx
);
   localparam logic [IW-1:0] ONE = IW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idx <= '0;
      else if (load)               idx <= load_val;
      else if (srst)               idx <= '0;
      else if (step && idx != '0)  idx <= idx + ONE;
   end
endmodule

// File: rtl/sctl_pair_reg.sv
module sctl_pair_reg #(
   parameter int DW       = 8,
   parameter int CLR_BITS = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic          clr_top,
   input  logic [DW-1:0] din,
   output logic [2*DW-1:0] q
);
   localparam int CW = 2 * DW;

   generate
      if (CLR_BITS > DW) begin : g_bad
         $error("sctl_pair_reg: CLR_BITS exceeds the high byte");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (srst) q <= '0;
      else begin
         if (wr_lo) q[DW-1:0] <= din;
         if (wr_hi) q[CW-1:DW] <= q[CW-1:DW] | din;
         if (clr_top && CLR_BITS > 0)
            q[CW-1 -: ((CLR_BITS > 0) ? CLR_BITS : 1)] <= '0;
      end
   end
endmodule

// File: rtl/sctl_hdr_bank.sv
module sctl_hdr_bank #(
   parameter int DW     = 8,
   parameter int NBYTES = 4,
   parameter logic [NBYTES*DW-1:0] RST_VAL = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 srst,
   input  logic                 load,
   input  logic [NBYTES*DW-1:0] din,
   output logic [NBYTES*DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (srst)  q <= RST_VAL;
      else if (load)  q <= din;
   end
endmodule

// File: rtl/sctl_regport.sv
module sctl_regport
   import sctl_regport_pkg::*;
#(
   parameter int DW        = 8,
   parameter int IW        = 4,
   parameter int HDR_BYTES = 4,
   parameter int HDR_BANKS = 2,
   parameter int CLR_BITS  = 4,
   parameter logic [HDR_BYTES*DW-1:0] HDR0_RST = 32'h0100_0000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    idx_load,
   input  logic [IW-1:0]           idx_in,
   input  logic                    wr_en,
   input  logic [DW-1:0]           wr_data,
   input  logic                    rd_en,
   output logic [DW-1:0]           rd_data,
   output logic [IW-1:0]           index,
   input  logic                    dec_event,
   input  logic                    hdr_alt_wr,
   input  logic [HDR_BYTES*DW-1:0] hdr_in,
   input  logic [2*DW-1:0]         blk_ptr,
   input  logic [2*DW-1:0]         wr_addr,
   input  logic                    dest_host,
   input  logic                    xfer_end,
   input  logic                    lvl5_en,
   output logic                    irq5,
   output logic                    xfer_start,
   output logic [2*DW-1:0]         byte_count,
   output logic [2*DW-1:0]         data_addr,
   output logic                    eod,
   output logic                    dec_enable
);
   localparam int CW  = 2 * DW;
   localparam int HW  = HDR_BYTES * DW;
   localparam int BSW = (HDR_BANKS > 1) ? $clog2(HDR_BANKS) : 1;

   generate
      if (IW != 4)         begin : g_bad_iw  $error("register map needs a 4-bit index"); end
      if (DW != 8)         begin : g_bad_dw  $error("register map is byte wide"); end
      if (HDR_BYTES != 4)  begin : g_bad_hb  $error("header read window holds 4 bytes"); end
      if (HDR_BANKS != 2)  begin : g_bad_bk  $error("bank select is a single bit"); end
   endgenerate

   // ---------------- access decode ----------------
   logic wr_go, rd_go, srst;
   assign wr_go = wr_en & ~idx_load;
   assign rd_go = rd_en & ~wr_en & ~idx_load;
   assign srst  = wr_go & (index == IX_SRST);

   logic [DW-1:0] ifctrl, ctrl0, ctrl1, stat0, stat2, stat3;
   if_flags_t     fl;
   logic          trig_ok, ack_wr;

   assign trig_ok = wr_go & (index == IX_TRIG) & ifctrl[B_OUT_EN];
   assign ack_wr  = wr_go & (index == IX_ACK);

   sctl_index_step #(.IW(IW)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .load     (idx_load),
      .load_val (idx_in),
      .step     (wr_go | rd_go),
      .idx      (index)
   );

   // ---------------- 16-bit pairs ----------------
   logic [CW-1:0] pair_q [2];
   generate
      for (genvar p = 0; p < 2; p++) begin : g_pair
         localparam logic [IW-1:0] LO = (p == 0) ? IX_CNT_LO : IX_ADR_LO;
         localparam logic [IW-1:0] HI = (p == 0) ? IX_CNT_HI : IX_ADR_HI;
         sctl_pair_reg #(.DW(DW), .CLR_BITS((p == 0) ? CLR_BITS : 0)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .srst    (srst),
            .wr_lo   (wr_go & (index == LO)),
            .wr_hi   (wr_go & (index == HI)),
            .clr_top ((p == 0) & (trig_ok | ack_wr)),
            .din     (wr_data),
            .q       (pair_q[p])
         );
      end
   endgenerate
   assign byte_count = pair_q[0];
   assign data_addr  = pair_q[1];

   // ---------------- header sets ----------------
   logic          dec_take;
   logic [HW-1:0] hdr_q [HDR_BANKS];
   assign dec_take = dec_event & ctrl0[B_DECODE];

   generate
      for (genvar b = 0; b < HDR_BANKS; b++) begin : g_hdr
         sctl_hdr_bank #(
            .DW(DW), .NBYTES(HDR_BYTES),
            .RST_VAL((b == 0) ? HDR0_RST : '0)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .srst  (srst),
            .load  ((b == 0) ? dec_take : hdr_alt_wr),
            .din   (hdr_in),
            .q     (hdr_q[b])
         );
      end
   endgenerate

   // ---------------- control / status ----------------
   function automatic logic [DW-1:0] mode_bits(logic auto_md, logic [DW-1:0] c1);
      return auto_md ? (c1 & M_MODE_ONLY) : (c1 & M_MODE_FORM);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || srst) begin
         ifctrl     <= '0;
         ctrl0      <= '0;
         ctrl1      <= '0;
         stat0      <= '0;
         stat2      <= '0;
         stat3      <= ST3_IDLE;
         fl         <= '1;
         eod        <= 1'b0;
         xfer_start <= 1'b0;
      end else begin
         xfer_start <= 1'b0;
         if (xfer_end) begin
            fl.busy_n <= 1'b1;
            fl.data_n <= 1'b1;
            fl.xe_n   <= 1'b0;
            eod       <= 1'b1;
         end
         if (rd_go && index == IX_ST3) begin
            stat3    <= ST3_IDLE;
            fl.dec_n <= 1'b1;
         end
         if (dec_take) begin
            stat3    <= '0;
            fl.dec_n <= 1'b0;
         end
         if (wr_go) begin
            unique case (index)
               IX_IFACE: begin
                  ifctrl <= wr_data;
                  if (!wr_data[B_OUT_EN]) begin
                     fl.busy_n <= 1'b1;
                     fl.data_n <= 1'b1;
                  end
               end
               IX_TRIG: if (ifctrl[B_OUT_EN]) begin
                  fl.busy_n  <= 1'b0;
                  if (dest_host) fl.data_n <= 1'b0;
                  eod        <= 1'b0;
                  xfer_start <= 1'b1;
               end
               IX_ACK:  fl.xe_n <= 1'b1;
               IX_CTL0: begin
                  ctrl0 <= wr_data;
                  stat0 <= wr_data & 8'h80;
                  stat2 <= mode_bits(wr_data[B_AUTO], ctrl1);
               end
               IX_CTL1: begin
                  ctrl1 <= wr_data;
                  stat2 <= mode_bits(ctrl0[B_AUTO], wr_data);
               end
               default: ;
            endcase
         end
      end
   end

   assign dec_enable = ctrl0[B_DECODE];

   assign irq5 = lvl5_en & ((ifctrl[B_XE_EN]  & ~fl.xe_n) |
                            (ifctrl[B_DEC_EN] & ~fl.dec_n));

   // ---------------- read mux ----------------
   logic [HW-1:0]  hdr_sel;
   logic [DW-1:0]  ifstat;
   assign hdr_sel = hdr_q[ctrl1[BSW-1:0]];
   assign ifstat  = {1'b1, fl.xe_n, fl.dec_n, 1'b1, fl.busy_n, 1'b1, fl.data_n, 1'b1};

   always_comb begin
      rd_data = '0;
      unique case (index)
         IX_IFACE:  rd_data = ifstat;
         IX_CNT_LO: rd_data = byte_count[DW-1:0];
         IX_CNT_HI: rd_data = byte_count[CW-1:DW];
         IX_PTR_LO: rd_data = blk_ptr[DW-1:0];
         IX_PTR_HI: rd_data = blk_ptr[CW-1:DW];
         IX_WA_LO:  rd_data = wr_addr[DW-1:0];
         IX_WA_HI:  rd_data = wr_addr[CW-1:DW];
         IX_ST0:    rd_data = stat0;
         IX_ST1:    rd_data = '0;
         IX_ST2:    rd_data = stat2;
         IX_ST3:    rd_data = stat3;
         default: begin
            if (index >= IX_HDR0 && index <= IX_HDR3)
               rd_data = hdr_sel[DW*32'(index - IX_HDR0) +: DW];
         end
      endcase
   end
endmodule

// File: rtl/sctl_regport_chk.sv
module sctl_regport_chk #(
   parameter int DW = 8,
   parameter int IW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          idx_load,
   input logic [IW-1:0] index,
   input logic          wr_en,
   input logic          rd_en,
   input logic [DW-1:0] rd_data,
   input logic          lvl5_en,
   input logic          irq5,
   input logic          xfer_start,
   input logic [2*DW-1:0] byte_count,
   input logic          eod,
   input logic          dec_enable
);
   assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_load && index != '0) |=> index == IW'($past(index) + 1'b1));

   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && !idx_load && index == '0) |=> index == '0);

   assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && !idx_load && index != '0) |=> index == IW'($past(index) + 1'b1));

   assert_stat1_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (index == IW'(13)) |-> rd_data == '0);

   assert_trig_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (byte_count[2*DW-1 -: 4] == 4'h0 && !eod));

   assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl5_en |-> !irq5);

   assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_load && index == '1) |=> (index == '0 && byte_count == '0 && !dec_enable && !irq5));
endmodule

bind sctl_regport sctl_regport_chk #(.DW(DW), .IW(IW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .idx_load   (idx_load),
   .index      (index),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .rd_data    (rd_data),
   .lvl5_en    (lvl5_en),
   .irq5       (irq5),
   .xfer_start (xfer_start),
   .byte_count (byte_count),
   .eod        (eod),
   .dec_enable (dec_enable)
);

// File: tb/tb_sctl_regport.sv
module tb_sctl_regport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_load = 0, wr_en = 0, rd_en = 0;
   logic [3:0]  idx_in = 0;
   logic [7:0]  wr_data = 0;
   logic [7:0]  rd_data;
   logic [3:0]  index;
   logic        dec_event = 0, hdr_alt_wr = 0, dest_host = 0, xfer_end = 0, lvl5_en = 0;
   logic [31:0] hdr_in = 0;
   logic [15:0] blk_ptr = 16'h1234, wr_addr = 16'hBEEF;
   logic        irq5, xfer_start, eod, dec_enable;
   logic [15:0] byte_count, data_addr;

   always #10 clk = ~clk;

   sctl_regport dut (
      .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_in(idx_in),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .index(index), .dec_event(dec_event), .hdr_alt_wr(hdr_alt_wr),
      .hdr_in(hdr_in), .blk_ptr(blk_ptr), .wr_addr(wr_addr),
      .dest_host(dest_host), .xfer_end(xfer_end), .lvl5_en(lvl5_en),
      .irq5(irq5), .xfer_start(xfer_start), .byte_count(byte_count),
      .data_addr(data_addr), .eod(eod), .dec_enable(dec_enable)
   );

   int    checks = 0, errors = 0;
   bit    done = 0;
   int    exp_q[$], got_q[$];
   string tag_q[$];
   event  pushed;

   // driver side of the scoreboard
   task automatic chk(input int got, input int exp, input string tag);
      exp_q.push_back(exp);
      got_q.push_back(got);
      tag_q.push_back(tag);
      -> pushed;
   endtask

   // monitor side
   always @(pushed) begin
      while (exp_q.size() > 0) begin
         int e, g;
         string t;
         e = exp_q.pop_front();
         g = got_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (g != e) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", t, g, e);
         end
      end
   end

   task automatic set_idx(input logic [3:0] v);
      @(negedge clk); idx_load = 1; idx_in = v;
      @(negedge clk); idx_load = 0;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); #1 v = rd_data; rd_en = 1;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic rd_chk(input logic [3:0] at, input int exp, input string tag);
      logic [7:0] v;
      set_idx(at);
      rd(v);
      chk(v, exp, tag);
   endtask

   task automatic pulse_end();
      @(negedge clk); xfer_end = 1;
      @(negedge clk); xfer_end = 0;
   endtask

   task automatic pulse_dec(input logic [31:0] h);
      @(negedge clk); dec_event = 1; hdr_in = h;
      @(negedge clk); dec_event = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got 0x1 expected 0x0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(index, 0, "R1 index");
      chk(irq5, 0, "R1 irq5");
      chk(byte_count, 0, "R1 count");
      chk(eod, 0, "R1 eod");
      rd_chk(4'h1, 8'hFF, "R1 status");
      chk(index, 2, "R3 index after status read");
      // R3 read map sweep from index 2
      rd(v); chk(v, 8'h00, "R3 count lo");
      rd(v); chk(v, 8'h00, "R3 count hi");
      rd(v); chk(v, 8'h00, "R1 hdr0 b0");
      rd(v); chk(v, 8'h00, "R1 hdr0 b1");
      rd(v); chk(v, 8'h00, "R1 hdr0 b2");
      rd(v); chk(v, 8'h01, "R1 hdr0 b3");
      rd(v); chk(v, 8'h34, "R3 blk_ptr lo");
      rd(v); chk(v, 8'h12, "R3 blk_ptr hi");
      rd(v); chk(v, 8'hEF, "R3 wr_addr lo");
      rd(v); chk(v, 8'hBE, "R3 wr_addr hi");
      rd(v); chk(v, 8'h00, "R1 stat0");
      rd(v); chk(v, 8'h00, "R3 stat1");
      rd(v); chk(v, 8'h00, "R1 stat2");
      rd(v); chk(v, 8'h80, "R1 stat3");
      chk(index, 0, "R3 wrap after stat3");
      // R2 index 0 accesses
      wr(8'h55); chk(index, 0, "R2 write at 0");
      rd(v); chk(v, 0, "R2 read at 0"); chk(index, 0, "R2 index held");
      // R4 pairs
      set_idx(4'h2);
      wr(8'h34); chk(byte_count, 16'h0034, "R4 count lo");
      wr(8'h12); chk(byte_count, 16'h1234, "R4 count hi");
      wr(8'hCD); wr(8'hAB); chk(data_addr, 16'hABCD, "R4 address");
      chk(index, 6, "R2 index advance");
      set_idx(4'h3); wr(8'h40); chk(byte_count, 16'h5234, "R4 hi OR");
      set_idx(4'h2); wr(8'h99); chk(byte_count, 16'h5299, "R4 lo replace");
      // R7 start with output disabled
      set_idx(4'h6); wr(8'h00);
      chk(xfer_start, 0, "R7 no start when disabled");
      chk(byte_count, 16'h5299, "R7 count untouched");
      rd_chk(4'h1, 8'hFF, "R7 status untouched");
      // R7 start enabled
      set_idx(4'h1); wr(8'h62);
      dest_host = 1;
      set_idx(4'h6); wr(8'h00);
      chk(xfer_start, 1, "R7 start pulse");
      chk(byte_count, 16'h0299, "R7 count top cleared");
      @(negedge clk); chk(xfer_start, 0, "R7 pulse one cycle");
      rd_chk(4'h1, 8'hF5, "R7 busy and data low");
      // R14 / R11
      lvl5_en = 1;
      pulse_end();
      chk(eod, 1, "R14 eod");
      rd_chk(4'h1, 8'hBF, "R14 status");
      #1 chk(irq5, 1, "R11 irq from transfer end");
      lvl5_en = 0; #1 chk(irq5, 0, "R11 gated off");
      lvl5_en = 1;
      // R8 ack
      set_idx(4'h3); wr(8'hF0); chk(byte_count, 16'hF299, "R4 hi OR nibble");
      set_idx(4'h7); wr(8'h00);
      chk(byte_count, 16'h0299, "R8 count top cleared");
      rd_chk(4'h1, 8'hFF, "R8 status");
      #1 chk(irq5, 0, "R8 irq dropped");
      // R6 abort
      set_idx(4'h6); wr(8'h00);
      chk(eod, 0, "R7 eod cleared");
      rd_chk(4'h1, 8'hF5, "R7 busy again");
      set_idx(4'h1); wr(8'h60);
      rd_chk(4'h1, 8'hFF, "R6 abort");
      // R9 mode rule
      set_idx(4'hB); wr(8'h0D);
      rd_chk(4'hE, 8'h0C, "R9 stat2 no auto");
      set_idx(4'hA); wr(8'h90);
      chk(dec_enable, 1, "R9 dec_enable");
      rd_chk(4'hC, 8'h80, "R9 stat0");
      rd(v); chk(v, 8'h00, "R3 stat1 zero");
      rd(v); chk(v, 8'h08, "R9 stat2 auto");
      // R5 bank select (CTRL1 bit0 = 1)
      @(negedge clk); hdr_alt_wr = 1; hdr_in = 32'hA1B2C3D4;
      @(negedge clk); hdr_alt_wr = 0;
      rd_chk(4'h4, 8'hD4, "R5 set1 b0");
      rd(v); chk(v, 8'hC3, "R5 set1 b1");
      rd(v); chk(v, 8'hB2, "R5 set1 b2");
      rd(v); chk(v, 8'hA1, "R5 set1 b3");
      // R13 decode event
      pulse_dec(32'h11223344);
      rd_chk(4'h1, 8'hDF, "R13 dec flag low");
      #1 chk(irq5, 1, "R11 irq from decoder");
      set_idx(4'hB); wr(8'h0C);
      rd_chk(4'hE, 8'h08, "R9 ctrl1 under auto");
      rd_chk(4'h4, 8'h44, "R13 set0 b0");
      rd(v); chk(v, 8'h33, "R13 set0 b1");
      rd(v); rd(v); chk(v, 8'h11, "R13 set0 b3");
      // R10 stat3 read side effect
      rd_chk(4'hF, 8'h00, "R10 stat3 value");
      chk(index, 0, "R3 wrap");
      rd_chk(4'hF, 8'h80, "R10 stat3 reload");
      rd_chk(4'h1, 8'hFF, "R10 dec flag cleared");
      #1 chk(irq5, 0, "R10 irq dropped");
      // R13 ignored when decoding off
      set_idx(4'hA); wr(8'h00);
      rd_chk(4'hE, 8'h0C, "R9 stat2 after ctrl0 clear");
      pulse_dec(32'h55667788);
      rd_chk(4'h1, 8'hFF, "R13 ignored status");
      rd_chk(4'h4, 8'h44, "R13 ignored header");
      rd_chk(4'hF, 8'h80, "R13 ignored stat3");
      // R12 soft reset
      set_idx(4'hF); wr(8'h00);
      chk(index, 0, "R12 index");
      chk(byte_count, 0, "R12 count");
      chk(data_addr, 0, "R12 address");
      chk(dec_enable, 0, "R12 ctrl0");
      rd_chk(4'h7, 8'h01, "R12 header reset");
      rd_chk(4'h1, 8'hFF, "R12 status");
      #5;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule